// File: doc/BRIEF.md
# USB Host Register and Interrupt Unit

This block is the software-facing front end of a small full-speed USB host. It sits on a Wishbone bus clocked by the system, and it holds the host's control, status, interrupt and transfer-descriptor registers. A single byte-wide data window feeds the transmit FIFO on writes and drains the receive FIFO on reads. The FIFO storage and the packet engine sit outside this block. The block only produces the push and pop strobes and passes the byte through.

Four event sources feed a sticky interrupt status word: start-of-frame, transfer complete, error, and device attach. The attach source is seen as the bus line state leaving SE0. A mask selects which sticky bits drive the single interrupt line. Software clears a bit by writing a one to it.

The USB clock and the bus clock are asynchronous to each other. Transfer starts cross into the USB domain as toggle-synchronised pulses. Acceptances and events cross back the same way. Multi-bit engine status crosses as a snapshot that is handed over with a request/acknowledge toggle pair.

Top module: `usbh_regs_unit`

## Requirements
- R1: After reset, every readable register returns zero (receive-status bit 28 mirrors the idle input, driven low), and `irq_o`, `tx_flush_o`, `tx_push_o`, `rx_pop_o` and `usb_start_o` are low.
- R2: At byte offset 0x00, bits 7:0 are stored and read back, and drive these outputs: bit 0 `sof_en_o`, bits 2:1 `phy_opmode_o`, bits 4:3 `phy_xcvrsel_o`, bit 5 `phy_termsel_o`, bit 6 `phy_dp_pulldn_o`, bit 7 `phy_dm_pulldn_o`. Writing bit 8 as one gives a single-cycle `tx_flush_o` pulse, and bit 8 reads back as zero.
- R3: A write to offset 0x20 gives one `tx_push_o` pulse with `tx_byte_o` equal to write bits 7:0. A read of 0x20 returns `rx_byte_i` in bits 7:0 with zeros above it, and gives one `rx_pop_o` pulse.
- R4: A one-cycle pulse on `usb_sof_evt_i`, `usb_done_evt_i` or `usb_err_evt_i` sets interrupt status bit 0, 1 or 2 (offset 0x0C). The bit stays set until it is acknowledged.
- R5: Interrupt status bit 3 is set when the line state reported at status bits 1:0 (offset 0x04) changes from 00 (SE0) to any other value. It is not set again while the line stays away from SE0.
- R6: Writing offset 0x08 clears each status bit written as one and leaves the other bits unchanged. If a set arrives in the same cycle, the set wins. Offset 0x08 reads as zero.
- R7: Offset 0x10 holds a 4-bit mask in the status bit layout. `irq_o` is high exactly when some status bit and its mask bit are both one.
- R8: A write to offset 0x18 with bit 31 set, when no start is pending, does four things. It stores bits 30:28, 23:16 and 15:5, sets the pending flag (offset 0x1C bit 31), clears status bit 2, and produces exactly one `usb_start_o` pulse. The pending flag clears after a `usb_accept_i` pulse.
- R9: While the pending flag is set, writes to offset 0x18 change neither the stored token fields nor the pending flag, and they give no further `usb_start_o` pulse.
- R10: USB-domain status that is held steady appears coherently on the bus side. Offset 0x04 shows frame time in 31:16 and line state in 1:0. Offset 0x1C shows CRC error in 30, timeout in 29, idle in 28, response PID in 23:16 and receive count in 15:0.
- R11: Status bit 2 of offset 0x04 is sticky. It is set once the engine's receive-error input is seen high, and it stays set after that input falls, until the next transfer start.
- R12: Each bus access gets `wb_ack_o` one cycle after it is presented, for one cycle only. Unmapped or misaligned offsets read as zero.
- R13: Offset 0x14 stores and reads back the transmit length in its low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low |
| usb_clk | input | 1 | USB clock |
| usb_rst_n | input | 1 | USB-domain reset, active low |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Access acknowledge |
| irq_o | output | 1 | Masked interrupt |
| sof_en_o | output | 1 | Frame-start generation enable |
| phy_opmode_o | output | 2 | PHY operating mode |
| phy_xcvrsel_o | output | 2 | PHY transceiver select |
| phy_termsel_o | output | 1 | PHY termination select |
| phy_dp_pulldn_o | output | 1 | D+ pulldown enable |
| phy_dm_pulldn_o | output | 1 | D- pulldown enable |
| tx_flush_o | output | 1 | Transmit FIFO flush pulse |
| tx_push_o | output | 1 | Transmit FIFO push pulse |
| tx_byte_o | output | 8 | Byte to push |
| rx_pop_o | output | 1 | Receive FIFO pop pulse |
| rx_byte_i | input | 8 | Head byte of receive FIFO |
| xfer_len_o | output | LEN_W | Transmit length |
| tok_in_o | output | 1 | Transfer direction is IN |
| tok_ack_o | output | 1 | Answer IN data with a handshake |
| tok_data1_o | output | 1 | Use DATA1 toggle |
| tok_pid_o | output | 8 | Token PID |
| tok_dev_o | output | 7 | Device address |
| tok_ep_o | output | 4 | Endpoint number |
| usb_start_o | output | 1 | Start pulse, USB domain |
| usb_accept_i | input | 1 | Engine accepted start, USB domain |
| usb_sof_evt_i | input | 1 | Frame-start event |
| usb_done_evt_i | input | 1 | Transfer-complete event |
| usb_err_evt_i | input | 1 | Error event |
| usb_line_i | input | 2 | Line state |
| usb_rx_err_i | input | 1 | Receive error |
| usb_crc_err_i | input | 1 | CRC error |
| usb_timeout_i | input | 1 | Response timeout |
| usb_idle_i | input | 1 | Engine idle |
| usb_resp_pid_i | input | 8 | Received response PID |
| usb_rx_count_i | input | 16 | Received byte count |
| usb_sof_time_i | input | 16 | Frame time |

## Verification
The bench builds the unit with three synchroniser stages and the registered interrupt output. The longer chain stretches every crossing, so events and snapshots that are still in flight are visible while software acknowledges or masks bits. The registered variant exercises the extra cycle between a status change and `irq_o`. The clocks run at unrelated periods, so pulses, snapshot handovers and the pending flag are tested across drifting phase. The model allows a bounded window for each crossing instead of fixing its exact cycle.

// File: rtl/usbh_regs_pkg.sv
package usbh_regs_pkg;

   // Byte offsets of the register window
   localparam logic [7:0] OFF_CTRL  = 8'h00;
   localparam logic [7:0] OFF_STAT  = 8'h04;
   localparam logic [7:0] OFF_IACK  = 8'h08;
   localparam logic [7:0] OFF_ISTS  = 8'h0C;
   localparam logic [7:0] OFF_IMSK  = 8'h10;
   localparam logic [7:0] OFF_LEN   = 8'h14;
   localparam logic [7:0] OFF_TOKEN = 8'h18;
   localparam logic [7:0] OFF_RXST  = 8'h1C;
   localparam logic [7:0] OFF_DATA  = 8'h20;

   // Interrupt bit layout (shared by status, mask and acknowledge)
   localparam int unsigned IRQ_N    = 4;
   localparam int unsigned IRQ_SOF  = 0;
   localparam int unsigned IRQ_DONE = 1;
   localparam int unsigned IRQ_ERR  = 2;
   localparam int unsigned IRQ_DET  = 3;

   // Token word: kept bits 30:28, 23:16, 15:5; bit 31 requests a start
   localparam int unsigned TOK_GO   = 31;
   localparam logic [30:0] TOK_KEEP = 31'h70FF_FFE0;

   // Snapshot of engine status carried across the clock boundary
   typedef struct packed {
      logic [15:0] sof_time;
      logic [1:0]  line;
      logic        rx_err;
      logic        crc_err;
      logic        timeout;
      logic        idle;
      logic [7:0]  resp_pid;
      logic [15:0] rx_cnt;
   } usb_stat_t;

endpackage

// File: rtl/usbh_pulse_cdc.sv
module usbh_pulse_cdc #(
   parameter int unsigned STAGES = 2
) (
   input  logic src_clk,
   input  logic src_rst_n,
   input  logic src_pulse,
   input  logic dst_clk,
   input  logic dst_rst_n,
   output logic dst_pulse
);

   logic              src_tgl;
   logic [STAGES-1:0] sync_q;
   logic              dst_last;

   if (STAGES < 2) begin : g_bad_stages
      $error("usbh_pulse_cdc: STAGES must be at least 2");
   end

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n)     src_tgl <= 1'b0;
      else if (src_pulse) src_tgl <= ~src_tgl;
   end

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) begin
         sync_q   <= '0;
         dst_last <= 1'b0;
      end else begin
         sync_q   <= {sync_q[STAGES-2:0], src_tgl};
         dst_last <= sync_q[STAGES-1];
      end
   end

   assign dst_pulse = sync_q[STAGES-1] ^ dst_last;

endmodule

// File: rtl/usbh_stat_cdc.sv
module usbh_stat_cdc #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic [W-1:0] src_data,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic [W-1:0] dst_data,
   output logic         dst_new
);

   logic [W-1:0] snap_q;
   logic         busy_q;
   logic         cap;
   logic         upd;
   logic         freed;

   // source side: capture when idle and the live value moved
   assign cap = !busy_q && (src_data != snap_q);

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) begin
         snap_q <= '0;
         busy_q <= 1'b0;
      end else begin
         if (cap) begin
            snap_q <= src_data;
            busy_q <= 1'b1;
         end else if (freed) begin
            busy_q <= 1'b0;
         end
      end
   end

   usbh_pulse_cdc #(.STAGES(STAGES)) u_req (
      .src_clk  (src_clk),  .src_rst_n (src_rst_n), .src_pulse (cap),
      .dst_clk  (dst_clk),  .dst_rst_n (dst_rst_n), .dst_pulse (upd)
   );

   usbh_pulse_cdc #(.STAGES(STAGES)) u_ret (
      .src_clk  (dst_clk),  .src_rst_n (dst_rst_n), .src_pulse (upd),
      .dst_clk  (src_clk),  .dst_rst_n (src_rst_n), .dst_pulse (freed)
   );

   // destination side: snapshot is frozen while busy, safe to sample on upd
   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) begin
         dst_data <= '0;
         dst_new  <= 1'b0;
      end else begin
         if (upd) dst_data <= snap_q;
         dst_new <= upd;
      end
   end

endmodule

// File: rtl/usbh_irq_ctrl.sv
module usbh_irq_ctrl #(
   parameter int unsigned N       = 4,
   parameter int unsigned IRQ_REG = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic         mask_we_i,
   input  logic [N-1:0] mask_wdata_i,
   output logic [N-1:0] sts_o,
   output logic [N-1:0] mask_o,
   output logic         irq_o
);

   logic any_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_o  <= '0;
         mask_o <= '0;
      end else begin
         sts_o <= (sts_o & ~clr_i) | set_i;
         if (mask_we_i) mask_o <= mask_wdata_i;
      end
   end

   assign any_hit = |(sts_o & mask_o);

   if (IRQ_REG != 0) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= any_hit;
      end
   end else begin : g_irq_comb
      assign irq_o = any_hit;
   end

endmodule

// File: rtl/usbh_regs_unit.sv
module usbh_regs_unit
   import usbh_regs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned IRQ_REG     = 0
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              usb_clk,
   input  logic              usb_rst_n,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADDR_W-1:0] wb_adr_i,
   input  logic [31:0]       wb_dat_i,
   output logic [31:0]       wb_dat_o,
   output logic              wb_ack_o,
   output logic              irq_o,
   output logic              sof_en_o,
   output logic [1:0]        phy_opmode_o,
   output logic [1:0]        phy_xcvrsel_o,
   output logic              phy_termsel_o,
   output logic              phy_dp_pulldn_o,
   output logic              phy_dm_pulldn_o,
   output logic              tx_flush_o,
   output logic              tx_push_o,
   output logic [7:0]        tx_byte_o,
   output logic              rx_pop_o,
   input  logic [7:0]        rx_byte_i,
   output logic [LEN_W-1:0]  xfer_len_o,
   output logic              tok_in_o,
   output logic              tok_ack_o,
   output logic              tok_data1_o,
   output logic [7:0]        tok_pid_o,
   output logic [6:0]        tok_dev_o,
   output logic [3:0]        tok_ep_o,
   output logic              usb_start_o,
   input  logic              usb_accept_i,
   input  logic              usb_sof_evt_i,
   input  logic              usb_done_evt_i,
   input  logic              usb_err_evt_i,
   input  logic [1:0]        usb_line_i,
   input  logic              usb_rx_err_i,
   input  logic              usb_crc_err_i,
   input  logic              usb_timeout_i,
   input  logic              usb_idle_i,
   input  logic [7:0]        usb_resp_pid_i,
   input  logic [15:0]       usb_rx_count_i,
   input  logic [15:0]       usb_sof_time_i
);

   localparam int unsigned WORD_W = ADDR_W - 2;
   localparam int unsigned EVT_N  = 3;
   localparam int unsigned STAT_W = $bits(usb_stat_t);

   // ---------------- elaboration checks ----------------
   if (ADDR_W < 6) begin : g_bad_addr
      $error("usbh_regs_unit: ADDR_W must cover offset 0x20");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("usbh_regs_unit: SYNC_STAGES must be at least 2");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("usbh_regs_unit: LEN_W must be 1..16");
   end
   if (IRQ_REG > 1) begin : g_bad_irq
      $error("usbh_regs_unit: IRQ_REG is 0 or 1");
   end

   function automatic logic at_off(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return (a[1:0] == 2'b00) && (a[ADDR_W-1:2] == WORD_W'(off[7:2]));
   endfunction

   // ---------------- bus access decode ----------------
   logic acc, wr, rd;
   logic hit_ctrl, hit_stat, hit_iack, hit_ists, hit_imsk;
   logic hit_len, hit_tok, hit_rxst, hit_data;

   assign acc = wb_cyc_i && wb_stb_i && !wb_ack_o;
   assign wr  = acc && wb_we_i;
   assign rd  = acc && !wb_we_i;

   assign hit_ctrl = at_off(wb_adr_i, OFF_CTRL);
   assign hit_stat = at_off(wb_adr_i, OFF_STAT);
   assign hit_iack = at_off(wb_adr_i, OFF_IACK);
   assign hit_ists = at_off(wb_adr_i, OFF_ISTS);
   assign hit_imsk = at_off(wb_adr_i, OFF_IMSK);
   assign hit_len  = at_off(wb_adr_i, OFF_LEN);
   assign hit_tok  = at_off(wb_adr_i, OFF_TOKEN);
   assign hit_rxst = at_off(wb_adr_i, OFF_RXST);
   assign hit_data = at_off(wb_adr_i, OFF_DATA);

   // ---------------- crossings ----------------
   logic [EVT_N-1:0] usb_evt;
   logic [EVT_N-1:0] bus_evt;
   logic             start_bus;
   logic             accept_bus;
   usb_stat_t        usb_live;
   usb_stat_t        stat_q;
   logic             stat_new;

   assign usb_evt = {usb_err_evt_i, usb_done_evt_i, usb_sof_evt_i};

   for (genvar e = 0; e < EVT_N; e++) begin : g_evt
      usbh_pulse_cdc #(.STAGES(SYNC_STAGES)) u_evt (
         .src_clk (usb_clk), .src_rst_n (usb_rst_n), .src_pulse (usb_evt[e]),
         .dst_clk (bus_clk), .dst_rst_n (bus_rst_n), .dst_pulse (bus_evt[e])
      );
   end

   usbh_pulse_cdc #(.STAGES(SYNC_STAGES)) u_start (
      .src_clk (bus_clk), .src_rst_n (bus_rst_n), .src_pulse (start_bus),
      .dst_clk (usb_clk), .dst_rst_n (usb_rst_n), .dst_pulse (usb_start_o)
   );

   usbh_pulse_cdc #(.STAGES(SYNC_STAGES)) u_accept (
      .src_clk (usb_clk), .src_rst_n (usb_rst_n), .src_pulse (usb_accept_i),
      .dst_clk (bus_clk), .dst_rst_n (bus_rst_n), .dst_pulse (accept_bus)
   );

   always_comb begin
      usb_live          = '0;
      usb_live.sof_time = usb_sof_time_i;
      usb_live.line     = usb_line_i;
      usb_live.rx_err   = usb_rx_err_i;
      usb_live.crc_err  = usb_crc_err_i;
      usb_live.timeout  = usb_timeout_i;
      usb_live.idle     = usb_idle_i;
      usb_live.resp_pid = usb_resp_pid_i;
      usb_live.rx_cnt   = usb_rx_count_i;
   end

   usbh_stat_cdc #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_stat (
      .src_clk   (usb_clk),
      .src_rst_n (usb_rst_n),
      .src_data  (usb_live),
      .dst_clk   (bus_clk),
      .dst_rst_n (bus_rst_n),
      .dst_data  (stat_q),
      .dst_new   (stat_new)
   );

   // ---------------- bus-domain registers ----------------
   logic [7:0]       ctrl_q;
   logic [LEN_W-1:0] len_q;
   logic [30:0]      tok_q;
   logic             pend_q;
   logic             rxerr_q;
   logic [1:0]       line_prev_q;
   logic             det_evt;

   assign start_bus = wr && hit_tok && wb_dat_i[TOK_GO] && !pend_q;
   assign det_evt   = (line_prev_q == 2'b00) && (stat_q.line != 2'b00);

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         ctrl_q      <= '0;
         len_q       <= '0;
         tok_q       <= '0;
         pend_q      <= 1'b0;
         rxerr_q     <= 1'b0;
         line_prev_q <= 2'b00;
      end else begin
         line_prev_q <= stat_q.line;
         if (wr && hit_ctrl) ctrl_q <= wb_dat_i[7:0];
         if (wr && hit_len)  len_q  <= wb_dat_i[LEN_W-1:0];
         if (wr && hit_tok && !pend_q) tok_q <= wb_dat_i[30:0] & TOK_KEEP;
         if (start_bus)       pend_q <= 1'b1;
         else if (accept_bus) pend_q <= 1'b0;
         if (stat_new && stat_q.rx_err) rxerr_q <= 1'b1;
         else if (start_bus)            rxerr_q <= 1'b0;
      end
   end

   // ---------------- strobes and bus response ----------------
   logic [31:0] rdata;

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         wb_ack_o   <= 1'b0;
         wb_dat_o   <= '0;
         tx_flush_o <= 1'b0;
         tx_push_o  <= 1'b0;
         tx_byte_o  <= '0;
         rx_pop_o   <= 1'b0;
      end else begin
         wb_ack_o   <= acc;
         tx_flush_o <= wr && hit_ctrl && wb_dat_i[8];
         tx_push_o  <= wr && hit_data;
         rx_pop_o   <= rd && hit_data;
         if (wr && hit_data) tx_byte_o <= wb_dat_i[7:0];
         if (rd) wb_dat_o <= rdata;
      end
   end

   // ---------------- interrupts ----------------
   logic [IRQ_N-1:0] irq_set, irq_clr, irq_sts, irq_mask;

   always_comb begin
      irq_set           = '0;
      irq_set[IRQ_SOF]  = bus_evt[0];
      irq_set[IRQ_DONE] = bus_evt[1];
      irq_set[IRQ_ERR]  = bus_evt[2];
      irq_set[IRQ_DET]  = det_evt;
      irq_clr           = (wr && hit_iack) ? wb_dat_i[IRQ_N-1:0] : '0;
   end

   usbh_irq_ctrl #(.N(IRQ_N), .IRQ_REG(IRQ_REG)) u_irq (
      .clk          (bus_clk),
      .rst_n        (bus_rst_n),
      .set_i        (irq_set),
      .clr_i        (irq_clr),
      .mask_we_i    (wr && hit_imsk),
      .mask_wdata_i (wb_dat_i[IRQ_N-1:0]),
      .sts_o        (irq_sts),
      .mask_o       (irq_mask),
      .irq_o        (irq_o)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rdata = '0;
      unique case (1'b1)
         hit_ctrl: rdata[7:0] = ctrl_q;
         hit_stat: begin
            rdata[31:16] = stat_q.sof_time;
            rdata[2]     = rxerr_q;
            rdata[1:0]   = stat_q.line;
         end
         hit_ists: rdata[IRQ_N-1:0] = irq_sts;
         hit_imsk: rdata[IRQ_N-1:0] = irq_mask;
         hit_len:  rdata[LEN_W-1:0] = len_q;
         hit_tok:  rdata[30:0] = tok_q;
         hit_rxst: begin
            rdata[31]    = pend_q;
            rdata[30]    = stat_q.crc_err;
            rdata[29]    = stat_q.timeout;
            rdata[28]    = stat_q.idle;
            rdata[23:16] = stat_q.resp_pid;
            rdata[15:0]  = stat_q.rx_cnt;
         end
         hit_data: rdata[7:0] = rx_byte_i;
         default:  rdata = '0;
      endcase
   end

   // ---------------- field outputs ----------------
   assign sof_en_o        = ctrl_q[0];
   assign phy_opmode_o    = ctrl_q[2:1];
   assign phy_xcvrsel_o   = ctrl_q[4:3];
   assign phy_termsel_o   = ctrl_q[5];
   assign phy_dp_pulldn_o = ctrl_q[6];
   assign phy_dm_pulldn_o = ctrl_q[7];
   assign xfer_len_o      = len_q;
   assign tok_in_o        = tok_q[30];
   assign tok_ack_o       = tok_q[29];
   assign tok_data1_o     = tok_q[28];
   assign tok_pid_o       = tok_q[23:16];
   assign tok_dev_o       = tok_q[15:9];
   assign tok_ep_o        = tok_q[8:5];

endmodule

// File: rtl/usbh_regs_unit_chk.sv
module usbh_regs_unit_chk (
   input logic        bus_clk,
   input logic        bus_rst_n,
   input logic        wb_cyc,
   input logic        wb_stb,
   input logic        wb_ack,
   input logic        irq,
   input logic [3:0]  sts,
   input logic [3:0]  mask,
   input logic [3:0]  set_v,
   input logic [3:0]  clr_v,
   input logic        tx_flush,
   input logic        tx_push,
   input logic        rx_pop,
   input logic        pend,
   input logic        accept,
   input logic [30:0] tok
);

   assert_ack_follows_R12: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (wb_cyc && wb_stb && !wb_ack) |=> wb_ack);

   assert_ack_single_R12: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      wb_ack |=> !wb_ack);

   assert_flush_pulse_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      tx_flush |=> !tx_flush);

   assert_push_pulse_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      tx_push |=> !tx_push);

   assert_pop_pulse_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      rx_pop |=> !rx_pop);

   assert_sticky_hold_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (sts & ~clr_v) != 4'd0 |=> (sts & $past(sts & ~clr_v)) == $past(sts & ~clr_v));

   assert_set_wins_R6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      set_v != 4'd0 |=> (sts & $past(set_v)) == $past(set_v));

   assert_irq_low_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      ((sts & mask) == 4'd0 && $past((sts & mask) == 4'd0)) |-> !irq);

   assert_irq_high_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      ((sts & mask) != 4'd0 && $past((sts & mask) != 4'd0)) |-> irq);

   assert_pend_hold_R8: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (pend && !accept) |=> pend);

   assert_tok_frozen_R9: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      pend |=> $stable(tok));

endmodule

bind usbh_regs_unit usbh_regs_unit_chk chk_i (
   .bus_clk   (bus_clk),
   .bus_rst_n (bus_rst_n),
   .wb_cyc    (wb_cyc_i),
   .wb_stb    (wb_stb_i),
   .wb_ack    (wb_ack_o),
   .irq       (irq_o),
   .sts       (irq_sts),
   .mask      (irq_mask),
   .set_v     (irq_set),
   .clr_v     (irq_clr),
   .tx_flush  (tx_flush_o),
   .tx_push   (tx_push_o),
   .rx_pop    (rx_pop_o),
   .pend      (pend_q),
   .accept    (accept_bus),
   .tok       (tok_q)
);

// File: tb/usbh_regs_unit_tb_top.sv
module usbh_regs_unit_tb_top;

   localparam int BUS_PERIOD = 10;
   localparam int USB_PERIOD = 17;

   logic bus_clk = 0, usb_clk = 0, bus_rst_n = 0, usb_rst_n = 0;
   always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
   always #(USB_PERIOD/2) usb_clk = ~usb_clk;

   logic        cyc = 0, stb = 0, we = 0;
   logic [7:0]  adr = 0;
   logic [31:0] dw = 0, dr;
   logic        ack, irq;
   logic        sof_en, termsel, dppd, dmpd, flush, push, pop;
   logic [1:0]  opmode, xcvr;
   logic [7:0]  tx_byte, rx_byte = 0;
   logic [15:0] xlen;
   logic        t_in, t_ack, t_d1, u_start;
   logic [7:0]  t_pid;
   logic [6:0]  t_dev;
   logic [3:0]  t_ep;
   logic        u_accept = 0, u_sof = 0, u_done = 0, u_err = 0;
   logic [1:0]  u_line = 0;
   logic        u_rxerr = 0, u_crc = 0, u_to = 0, u_idle = 0;
   logic [7:0]  u_pid = 0;
   logic [15:0] u_cnt = 0, u_time = 0;

   usbh_regs_unit #(.ADDR_W(8), .SYNC_STAGES(3), .LEN_W(16), .IRQ_REG(1)) dut_i (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .usb_clk(usb_clk), .usb_rst_n(usb_rst_n),
      .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(dw),
      .wb_dat_o(dr), .wb_ack_o(ack), .irq_o(irq),
      .sof_en_o(sof_en), .phy_opmode_o(opmode), .phy_xcvrsel_o(xcvr), .phy_termsel_o(termsel),
      .phy_dp_pulldn_o(dppd), .phy_dm_pulldn_o(dmpd), .tx_flush_o(flush),
      .tx_push_o(push), .tx_byte_o(tx_byte), .rx_pop_o(pop), .rx_byte_i(rx_byte),
      .xfer_len_o(xlen), .tok_in_o(t_in), .tok_ack_o(t_ack), .tok_data1_o(t_d1),
      .tok_pid_o(t_pid), .tok_dev_o(t_dev), .tok_ep_o(t_ep),
      .usb_start_o(u_start), .usb_accept_i(u_accept),
      .usb_sof_evt_i(u_sof), .usb_done_evt_i(u_done), .usb_err_evt_i(u_err),
      .usb_line_i(u_line), .usb_rx_err_i(u_rxerr), .usb_crc_err_i(u_crc),
      .usb_timeout_i(u_to), .usb_idle_i(u_idle), .usb_resp_pid_i(u_pid),
      .usb_rx_count_i(u_cnt), .usb_sof_time_i(u_time)
   );

   int total = 0, bad = 0;
   int flush_cnt = 0, push_cnt = 0, pop_cnt = 0, start_cnt = 0;
   int last_waits = 0;
   bit done_flag = 0;

   // behavioural model of the interrupt state
   logic [3:0] m_sts = 0, m_mask = 0;
   bit cmp_en = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison of irq against the model (R7)
   always @(negedge bus_clk) begin
      if (bus_rst_n && cmp_en && !done_flag) chk("R7 irq per clock", {31'd0, irq}, {31'd0, |(m_sts & m_mask)});
   end

   always @(negedge bus_clk) begin
      if (flush) flush_cnt++;
      if (push)  push_cnt++;
      if (pop)   pop_cnt++;
   end
   always @(negedge usb_clk) if (u_start) start_cnt++;

   task automatic wb_acc(input logic [7:0] a, input bit w, input logic [31:0] wd, output logic [31:0] rdv);
      int waits;
      @(negedge bus_clk);
      cyc = 1; stb = 1; we = w; adr = a; dw = wd;
      waits = 0;
      do begin @(negedge bus_clk); waits++; end while (!ack && waits < 10);
      rdv = dr; last_waits = waits;
      cyc = 0; stb = 0; we = 0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] unused_rd;
      wb_acc(a, 1'b1, d, unused_rd);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      wb_acc(a, 1'b0, 32'd0, d);
   endtask

   task automatic poll(input logic [7:0] a, input logic [31:0] msk, input logic [31:0] exp, output logic [31:0] got);
      for (int i = 0; i < 60; i++) begin
         rd(a, got);
         if ((got & msk) == exp) break;
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge bus_clk);
      cmp_en = 1;
   endtask

   task automatic usb_pulse(input int which);
      @(negedge usb_clk);
      case (which)
         0: u_sof = 1; 1: u_done = 1; 2: u_err = 1; default: u_accept = 1;
      endcase
      @(negedge usb_clk);
      u_sof = 0; u_done = 0; u_err = 0; u_accept = 0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(BUS_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int p0, s0;
      repeat (5) @(negedge bus_clk);
      bus_rst_n = 1; usb_rst_n = 1;
      repeat (3) @(negedge bus_clk);

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 strobes", {28'd0, flush, push, pop, u_start}, 0);
      rd(8'h00, v); chk("R1 ctrl", v, 0);
      rd(8'h04, v); chk("R1 status", v, 0);
      rd(8'h0C, v); chk("R1 irq status", v, 0);
      rd(8'h10, v); chk("R1 mask", v, 0);
      rd(8'h14, v); chk("R1 length", v, 0);
      rd(8'h18, v); chk("R1 token", v, 0);
      rd(8'h1C, v); chk("R1 rx status", v, 0);
      settle();

      // R12 ack timing and unmapped reads
      rd(8'h24, v); chk("R12 unmapped read", v, 0);
      chk("R12 ack latency", last_waits, 1);
      rd(8'h02, v); chk("R12 misaligned read", v, 0);

      // R2 control register and flush pulse
      wr(8'h00, 32'h0000_01A5);
      repeat (2) @(negedge bus_clk);
      chk("R2 flush pulse count", flush_cnt, 1);
      chk("R2 outputs", {24'd0, dmpd, dppd, termsel, xcvr, opmode, sof_en}, 32'h0000_00A5);
      rd(8'h00, v); chk("R2 readback", v, 32'h0000_00A5);
      wr(8'h00, 32'h0000_005A);
      chk("R2 outputs second", {24'd0, dmpd, dppd, termsel, xcvr, opmode, sof_en}, 32'h0000_005A);
      chk("R2 no flush without bit8", flush_cnt, 1);

      // R13 length
      wr(8'h14, 32'hFFFF_1234);
      rd(8'h14, v); chk("R13 length", v, 32'h0000_1234);
      chk("R13 length out", {16'd0, xlen}, 32'h0000_1234);

      // R3 data window
      wr(8'h20, 32'h0000_0155);
      repeat (2) @(negedge bus_clk);
      chk("R3 push count", push_cnt, 1);
      chk("R3 push byte", {24'd0, tx_byte}, 32'h55);
      wr(8'h20, 32'hFFFF_FF3C);
      repeat (2) @(negedge bus_clk);
      chk("R3 push byte 2", {24'd0, tx_byte}, 32'h3C);
      rx_byte = 8'hC3;
      rd(8'h20, v); chk("R3 read byte", v, 32'h0000_00C3);
      repeat (2) @(negedge bus_clk);
      chk("R3 pop count", pop_cnt, 1);
      chk("R3 push count 2", push_cnt, 2);

      // R7 mask, R4 events
      wr(8'h10, 32'h0000_000F); m_mask = 4'hF;
      rd(8'h10, v); chk("R7 mask readback", v, 32'hF);
      cmp_en = 0;
      usb_pulse(0); poll(8'h0C, 32'hF, 32'h1, v); chk("R4 sof event", v, 32'h1); m_sts = 4'h1; settle();
      chk("R7 irq high", {31'd0, irq}, 1);
      cmp_en = 0;
      usb_pulse(1); poll(8'h0C, 32'hF, 32'h3, v); chk("R4 done event", v, 32'h3);
      usb_pulse(2); poll(8'h0C, 32'hF, 32'h7, v); chk("R4 err event", v, 32'h7);
      m_sts = 4'h7; settle();
      repeat (20) @(negedge bus_clk);
      rd(8'h0C, v); chk("R4 sticky", v, 32'h7);

      // R6 acknowledge
      cmp_en = 0;
      wr(8'h08, 32'h0000_0002); m_sts = 4'h5;
      rd(8'h0C, v); chk("R6 ack clears one bit", v, 32'h5);
      rd(8'h08, v); chk("R6 ack reads zero", v, 0);
      settle();

      // R7 masking
      cmp_en = 0;
      wr(8'h10, 32'h0); m_mask = 0; settle();
      chk("R7 masked off", {31'd0, irq}, 0);
      cmp_en = 0;
      wr(8'h10, 32'h2); m_mask = 4'h2; settle();
      chk("R7 mask on cleared bit", {31'd0, irq}, 0);
      cmp_en = 0;
      wr(8'h10, 32'h4); m_mask = 4'h4; settle();
      chk("R7 mask on set bit", {31'd0, irq}, 1);
      cmp_en = 0;
      wr(8'h08, 32'h5); m_sts = 0;
      wr(8'h10, 32'hF); m_mask = 4'hF; settle();

      // R5 device detect
      cmp_en = 0;
      u_line = 2'b01;
      poll(8'h04, 32'h3, 32'h1, v); chk("R5 line seen", v & 32'h3, 32'h1);
      poll(8'h0C, 32'hF, 32'h8, v); chk("R5 detect set", v, 32'h8);
      wr(8'h08, 32'h8);
      repeat (40) @(negedge bus_clk);
      rd(8'h0C, v); chk("R5 no re-detect while attached", v, 0);
      m_sts = 0; settle();
      cmp_en = 0;
      u_line = 2'b00;
      poll(8'h04, 32'h3, 32'h0, v); chk("R5 back to SE0", v & 32'h3, 0);
      u_line = 2'b10;
      poll(8'h0C, 32'hF, 32'h8, v); chk("R5 detect again", v, 32'h8);
      wr(8'h08, 32'h8); m_sts = 0; settle();

      // R10 status snapshot
      cmp_en = 0;
      u_time = 16'h1234; u_crc = 1; u_idle = 1; u_pid = 8'h4B; u_cnt = 16'h0040;
      poll(8'h1C, 32'hFFFF_FFFF, 32'h504B_0040, v); chk("R10 rx status", v, 32'h504B_0040);
      poll(8'h04, 32'hFFFF_FFFF, 32'h1234_0002, v); chk("R10 status", v, 32'h1234_0002);
      settle();

      // R11 sticky receive error
      u_rxerr = 1;
      poll(8'h04, 32'h4, 32'h4, v); chk("R11 rx error set", v, 32'h1234_0006);
      u_rxerr = 0;
      repeat (60) @(negedge bus_clk);
      rd(8'h04, v); chk("R11 rx error sticky", v, 32'h1234_0006);

      // R8 transfer start
      s0 = start_cnt;
      wr(8'h18, 32'hE069_0A60);
      rd(8'h1C, v); chk("R8 pending set", v, 32'hD04B_0040);
      rd(8'h04, v); chk("R8 rx error cleared", v, 32'h1234_0002);
      rd(8'h18, v); chk("R8 token readback", v, 32'h6069_0A60);
      chk("R8 token fields", {t_in, t_ack, t_d1, t_pid, t_dev, t_ep, 10'd0},
          {1'b1, 1'b1, 1'b0, 8'h69, 7'd5, 4'd3, 10'd0});
      repeat (30) @(negedge bus_clk);
      chk("R8 one start pulse", start_cnt - s0, 1);

      // R9 writes ignored while pending
      wr(8'h18, 32'h9000_1111);
      repeat (30) @(negedge bus_clk);
      rd(8'h18, v); chk("R9 token unchanged", v, 32'h6069_0A60);
      rd(8'h1C, v); chk("R9 still pending", v[31], 1);
      chk("R9 no extra start", start_cnt - s0, 1);

      // R8 accept clears pending, then a new start works
      usb_pulse(3);
      poll(8'h1C, 32'h8000_0000, 32'h0, v); chk("R8 pending cleared", v[31], 0);
      p0 = start_cnt;
      wr(8'h18, 32'h9000_1111);
      rd(8'h18, v); chk("R8 second token", v, 32'h1000_1100);
      repeat (30) @(negedge bus_clk);
      chk("R8 second start pulse", start_cnt - p0, 1);

      finish_run();
   end

endmodule